// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory Entry

This block manages the coherence state of one memory line at its home node. It does not keep a presence bit per node. It keeps a small set of node-identifier pointers, NPTR of them (five by default), each $clog2(NODES) bits wide. Reads from nodes that fit in the pointer set are answered by hardware. A node that already holds a pointer is acknowledged without taking a second one.

When a read would need one more pointer than the entry has, the entry stops answering reads in hardware:
- The read is passed out on a trap port for a software handler.
- The stored pointers are pushed out one per cycle on a drain port, so the handler can merge them into an extended sharer vector.
- Once the drain is complete, the entry waits in a trap-on-write mode. Later reads and writes are forwarded to the trap port.

For a forwarded write, the handler returns the full sharer vector. The entry counts the sharers other than the writer and waits for that many invalidation acknowledgements. It then grants write permission and switches the line to read-write. A write in normal mode uses the pointers directly: it sends parallel invalidations to every pointer except the writer's and counts the acknowledgements in the same way. While the entry is busy, requests get a negative acknowledgement. A software-complete strobe in trap-on-write mode returns the entry to normal with no pointers valid.

Top module: `ldir_entry`

## Requirements
- R1: After reset, meta_o is 0 (normal), rw_o is 0, sharers_o is 0 and every pulse output is 0.
- R2: In normal mode (meta 0), a read from a node not in the pointer set while a pointer is free pulses rd_ack_o after the next clock edge, adds one to sharers_o and clears rw_o.
- R3: In normal mode, a read from a node already held in a pointer pulses rd_ack_o and leaves sharers_o unchanged.
- R4: In normal mode with all NPTR pointers valid, a read from a new node gives no rd_ack_o. It pulses trap_valid_o with trap_write_o=0 and trap_node_o equal to the reader, and meta_o becomes 1 (transfer in progress).
- R5: In meta 1, each of the next NPTR cycles pulses drain_valid_o with one stored node ID, in pointer-slot order (slot 0 first). With the last drain, meta_o becomes 2 (trap on write) and sharers_o becomes 0.
- R6: A request in meta 1, 3 (awaiting vector) or 4 (awaiting acks) pulses nak_o and changes no pointer, mode or grant output.
- R7: In meta 2, a read pulses trap_valid_o with trap_write_o=0 and the mode stays 2. A write pulses trap_valid_o with trap_write_o=1 and meta_o becomes 3.
- R8: In meta 3, a vector strobe loads the acknowledgement counter with the number of set bits in sw_vec_i other than the writer's bit. A nonzero count moves meta_o to 4. A zero count grants write permission at once.
- R9: In meta 4, the acknowledgement that brings the count to zero pulses wperm_valid_o with wperm_node_o equal to the writer after that edge. At the same edge rw_o is set, meta_o returns to 0 and sharers_o becomes 1 (the writer alone).
- R10: In normal mode, a write pulses inv_valid_o on every valid pointer slot whose node differs from the writer, with inv_node_o carrying all slots, and meta_o becomes 4. If no other sharer exists, write permission is granted after the same edge.
- R11: sw_done_i in meta 2 sets meta_o to 0 with sharers_o 0. In any other mode it has no effect.
- R12: ack_i outside meta 4 has no effect on mode, sharer count or grant outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write request, 0 = read request |
| req_node_i | input | NW | Requesting node ID |
| ack_i | input | 1 | One invalidation acknowledgement |
| sw_vec_valid_i | input | 1 | Handler supplies the sharer vector |
| sw_vec_i | input | NODES | Extended sharer vector, bit n = node n |
| sw_done_i | input | 1 | Handler finished with the entry |
| rd_ack_o | output | 1 | Hardware read reply pulse |
| nak_o | output | 1 | Negative acknowledgement pulse |
| trap_valid_o | output | 1 | Request forwarded to the handler |
| trap_write_o | output | 1 | Forwarded request is a write |
| trap_node_o | output | NW | Forwarded requester |
| drain_valid_o | output | 1 | Pointer being emptied |
| drain_node_o | output | NW | Node ID being emptied |
| inv_valid_o | output | NPTR | Per-slot invalidation pulse |
| inv_node_o | output | NPTR*NW | Node IDs of all slots, slot 0 in the low bits |
| wperm_valid_o | output | 1 | Write-permission pulse |
| wperm_node_o | output | NW | Node receiving write permission |
| meta_o | output | 3 | Mode: 0 normal, 1 transfer, 2 trap on write, 3 awaiting vector, 4 awaiting acks |
| rw_o | output | 1 | Line is in read-write state |
| sharers_o | output | $clog2(NPTR+1) | Number of valid pointers |

## Verification
A duplicated pointer or a misplaced free-slot choice shows up within one request: sharers_o is wrong, or the entry overflows one read too early or too late. That in turn moves the trap pulse and the whole drain sequence. A wrong acknowledgement count shows up as a write-permission pulse one or more cycles off from the last ack, or none at all. A wrong mode shows up at once as a missing NAK or an unexpected trap on the next request. The drain order and the invalidation slot mask expose the pointer contents themselves, so both are compared value by value.

// File: rtl/ldir_pkg.sv
package ldir_pkg;
   typedef enum logic [2:0] {
      M_NORMAL  = 3'd0,
      M_XFER    = 3'd1,
      M_TRAPWR  = 3'd2,
      M_VECWAIT = 3'd3,
      M_ACKWAIT = 3'd4
   } meta_e;
endpackage

// File: rtl/ldir_popcount.sv
module ldir_popcount #(
   parameter int W  = 8,
   parameter int OW = $clog2(W + 1)
) (
   input  logic [W-1:0]  bits_i,
   output logic [OW-1:0] count_o
);
   if (OW < $clog2(W + 1)) begin : g_bad_ow
      $error("ldir_popcount: OW too narrow");
   end

   always_comb begin
      count_o = '0;
      for (int i = 0; i < W; i++) count_o = count_o + OW'(bits_i[i]);
   end
endmodule

// File: rtl/ldir_ack_ctr.sv
module ldir_ack_ctr #(
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] load_val_i,
   input  logic          dec_i,
   output logic [AW-1:0] cnt_o,
   output logic          last_o
);
   logic [AW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (dec_i)  cnt_q <= cnt_q - AW'(1);
   end

   assign cnt_o  = cnt_q;
   assign last_o = (cnt_q == AW'(1));

   // R9
   ack_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !load_i) |-> (cnt_q != '0))
      else $error("ack counter decremented at zero");
endmodule

// File: rtl/ldir_ptr_file.sv
module ldir_ptr_file #(
   parameter int NODES = 16,
   parameter int NPTR  = 5,
   localparam int NW   = $clog2(NODES),
   localparam int IW   = (NPTR > 1) ? $clog2(NPTR) : 1,
   localparam int CW   = $clog2(NPTR + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NW-1:0]    look_node_i,
   input  logic             alloc_en_i,
   input  logic             solo_en_i,
   input  logic             clr_en_i,
   output logic [NPTR*NW-1:0] ptr_flat_o,
   output logic             hit_o,
   output logic             full_o,
   output logic [NPTR-1:0]  other_mask_o,
   output logic [CW-1:0]    cnt_o
);
   logic [NW-1:0]   ptr_q [NPTR];
   logic [NPTR-1:0] vld_q;
   logic [NPTR-1:0] match;
   logic [IW-1:0]   free_idx;

   for (genvar g = 0; g < NPTR; g++) begin : g_slot
      assign match[g] = vld_q[g] && (ptr_q[g] == look_node_i);
      assign ptr_flat_o[g*NW +: NW] = ptr_q[g];
   end

   always_comb begin
      free_idx = '0;
      for (int i = NPTR - 1; i >= 0; i--) if (!vld_q[i]) free_idx = IW'(i);
   end

   assign hit_o        = |match;
   assign full_o       = &vld_q;
   assign other_mask_o = vld_q & ~match;

   ldir_popcount #(.W(NPTR), .OW(CW)) u_cnt (.bits_i(vld_q), .count_o(cnt_o));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int i = 0; i < NPTR; i++) ptr_q[i] <= '0;
      end else if (clr_en_i) begin
         vld_q <= '0;
      end else if (solo_en_i) begin
         vld_q    <= NPTR'(1);
         ptr_q[0] <= look_node_i;
      end else if (alloc_en_i) begin
         vld_q[free_idx] <= 1'b1;
         ptr_q[free_idx] <= look_node_i;
      end
   end

   // R2
   alloc_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en_i |-> (!full_o && !hit_o))
      else $error("pointer allocated while full or already present");
   // R3
   dup_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match))
      else $error("same node held in two pointers");
endmodule

// File: rtl/ldir_entry.sv
module ldir_entry
   import ldir_pkg::*;
#(
   parameter int NODES = 16,
   parameter int NPTR  = 5,
   localparam int NW   = $clog2(NODES),
   localparam int CW   = $clog2(NPTR + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic              req_write_i,
   input  logic [NW-1:0]     req_node_i,
   input  logic              ack_i,
   input  logic              sw_vec_valid_i,
   input  logic [NODES-1:0]  sw_vec_i,
   input  logic              sw_done_i,
   output logic              rd_ack_o,
   output logic              nak_o,
   output logic              trap_valid_o,
   output logic              trap_write_o,
   output logic [NW-1:0]     trap_node_o,
   output logic              drain_valid_o,
   output logic [NW-1:0]     drain_node_o,
   output logic [NPTR-1:0]   inv_valid_o,
   output logic [NPTR*NW-1:0] inv_node_o,
   output logic              wperm_valid_o,
   output logic [NW-1:0]     wperm_node_o,
   output logic [2:0]        meta_o,
   output logic              rw_o,
   output logic [CW-1:0]     sharers_o
);
   localparam int IW = (NPTR > 1) ? $clog2(NPTR) : 1;
   localparam int AW = $clog2(NODES + 1);

   if (NODES < 2) begin : g_bad_nodes
      $error("ldir_entry: NODES must be at least 2");
   end
   if (NPTR < 1 || NPTR >= NODES) begin : g_bad_nptr
      $error("ldir_entry: NPTR must be in 1..NODES-1");
   end

   meta_e          meta_q;
   logic [IW-1:0]  didx_q;
   logic [NW-1:0]  writer_q;
   logic           rw_q;

   logic [NPTR*NW-1:0] ptr_flat;
   logic           hit, full;
   logic [NPTR-1:0] other_mask;
   logic [CW-1:0]  other_cnt, ptr_cnt;
   logic [NODES-1:0] wr_onehot;
   logic [AW-1:0]  vec_cnt, ack_cnt;
   logic           ack_last;

   logic is_rd, is_wr, vec_strobe, drain_last;
   logic alloc_en, solo_en, clr_en, ack_load, ack_dec;
   logic [AW-1:0] ack_load_val;
   logic [NW-1:0] look_node;

   assign is_rd      = req_valid_i && !req_write_i;
   assign is_wr      = req_valid_i &&  req_write_i;
   assign vec_strobe = (meta_q == M_VECWAIT) && sw_vec_valid_i;
   assign drain_last = (meta_q == M_XFER) && (didx_q == IW'(NPTR - 1));

   always_comb begin
      wr_onehot = '0;
      wr_onehot[writer_q] = 1'b1;
   end

   ldir_popcount #(.W(NPTR),  .OW(CW)) u_other (.bits_i(other_mask),           .count_o(other_cnt));
   ldir_popcount #(.W(NODES), .OW(AW)) u_vec   (.bits_i(sw_vec_i & ~wr_onehot), .count_o(vec_cnt));

   // grant events install the writer as the only pointer
   always_comb begin
      solo_en      = 1'b0;
      ack_load     = 1'b0;
      ack_load_val = '0;
      if (meta_q == M_NORMAL && is_wr) begin
         if (other_cnt == '0) solo_en = 1'b1;
         else begin
            ack_load     = 1'b1;
            ack_load_val = AW'(other_cnt);
         end
      end else if (vec_strobe) begin
         if (vec_cnt == '0) solo_en = 1'b1;
         else begin
            ack_load     = 1'b1;
            ack_load_val = vec_cnt;
         end
      end else if (meta_q == M_ACKWAIT && ack_i && ack_last) begin
         solo_en = 1'b1;
      end
   end

   assign ack_dec   = (meta_q == M_ACKWAIT) && ack_i;
   assign alloc_en  = (meta_q == M_NORMAL) && is_rd && !hit && !full;
   assign clr_en    = drain_last || ((meta_q == M_TRAPWR) && sw_done_i);
   assign look_node = (meta_q == M_NORMAL) ? req_node_i : writer_q;

   ldir_ptr_file #(.NODES(NODES), .NPTR(NPTR)) u_ptrs (
      .clk          (clk),
      .rst_n        (rst_n),
      .look_node_i  (look_node),
      .alloc_en_i   (alloc_en),
      .solo_en_i    (solo_en),
      .clr_en_i     (clr_en),
      .ptr_flat_o   (ptr_flat),
      .hit_o        (hit),
      .full_o       (full),
      .other_mask_o (other_mask),
      .cnt_o        (ptr_cnt)
   );

   ldir_ack_ctr #(.AW(AW)) u_ack (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (ack_load),
      .load_val_i (ack_load_val),
      .dec_i      (ack_dec),
      .cnt_o      (ack_cnt),
      .last_o     (ack_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meta_q        <= M_NORMAL;
         didx_q        <= '0;
         writer_q      <= '0;
         rw_q          <= 1'b0;
         rd_ack_o      <= 1'b0;
         nak_o         <= 1'b0;
         trap_valid_o  <= 1'b0;
         trap_write_o  <= 1'b0;
         trap_node_o   <= '0;
         drain_valid_o <= 1'b0;
         drain_node_o  <= '0;
         inv_valid_o   <= '0;
         inv_node_o    <= '0;
         wperm_valid_o <= 1'b0;
         wperm_node_o  <= '0;
      end else begin
         rd_ack_o      <= 1'b0;
         nak_o         <= 1'b0;
         trap_valid_o  <= 1'b0;
         trap_write_o  <= 1'b0;
         drain_valid_o <= 1'b0;
         inv_valid_o   <= '0;
         wperm_valid_o <= 1'b0;
         unique case (meta_q)
            M_NORMAL: begin
               if (is_rd) begin
                  rw_q <= 1'b0;
                  if (hit || !full) rd_ack_o <= 1'b1;
                  else begin
                     trap_valid_o <= 1'b1;
                     trap_node_o  <= req_node_i;
                     meta_q       <= M_XFER;
                     didx_q       <= '0;
                  end
               end else if (is_wr) begin
                  writer_q <= req_node_i;
                  if (other_cnt == '0) begin
                     wperm_valid_o <= 1'b1;
                     wperm_node_o  <= req_node_i;
                     rw_q          <= 1'b1;
                  end else begin
                     inv_valid_o <= other_mask;
                     inv_node_o  <= ptr_flat;
                     meta_q      <= M_ACKWAIT;
                  end
               end
            end
            M_XFER: begin
               nak_o         <= req_valid_i;
               drain_valid_o <= 1'b1;
               drain_node_o  <= ptr_flat[didx_q*NW +: NW];
               if (drain_last) meta_q <= M_TRAPWR;
               else            didx_q <= didx_q + IW'(1);
            end
            M_TRAPWR: begin
               if (sw_done_i) begin
                  nak_o  <= req_valid_i;
                  meta_q <= M_NORMAL;
               end else if (req_valid_i) begin
                  trap_valid_o <= 1'b1;
                  trap_write_o <= req_write_i;
                  trap_node_o  <= req_node_i;
                  if (req_write_i) begin
                     writer_q <= req_node_i;
                     meta_q   <= M_VECWAIT;
                  end
               end
            end
            M_VECWAIT: begin
               nak_o <= req_valid_i;
               if (sw_vec_valid_i) begin
                  if (vec_cnt == '0) begin
                     wperm_valid_o <= 1'b1;
                     wperm_node_o  <= writer_q;
                     rw_q          <= 1'b1;
                     meta_q        <= M_NORMAL;
                  end else meta_q <= M_ACKWAIT;
               end
            end
            M_ACKWAIT: begin
               nak_o <= req_valid_i;
               if (ack_i && ack_last) begin
                  wperm_valid_o <= 1'b1;
                  wperm_node_o  <= writer_q;
                  rw_q          <= 1'b1;
                  meta_q        <= M_NORMAL;
               end
            end
            default: meta_q <= M_NORMAL;
         endcase
      end
   end

   assign meta_o    = meta_q;
   assign rw_o      = rw_q;
   assign sharers_o = ptr_cnt;

   // R2
   rd_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack_o |-> (meta_o == 3'd0))
      else $error("read reply outside normal mode");
   // R5
   xfer_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (meta_q == M_XFER) |-> (sharers_o == CW'(NPTR)))
      else $error("pointers lost during transfer");
   // R6
   nak_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nak_o |-> !(rd_ack_o || trap_valid_o || wperm_valid_o))
      else $error("NAK together with a reply");
   // R8
   ack_wait_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (meta_q == M_ACKWAIT) |-> (ack_cnt != '0))
      else $error("waiting for acks with zero count");
   // R9
   grant_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wperm_valid_o |-> (rw_o && meta_o == 3'd0 && sharers_o == CW'(1)))
      else $error("grant without read-write state");
endmodule

// File: tb/ldir_entry_test.sv
`timescale 1ns/1ps
module ldir_entry_test;
   localparam int NODES = 16;
   localparam int NPTR  = 5;
   localparam int NW    = 4;

   typedef struct packed {
      logic [3:0]  rq;
      logic        rv, wr; logic [3:0] node; logic ack, vv; logic [15:0] vec; logic done;
      logic        rd, nak, trap, tw; logic [3:0] tn; logic dr; logic [3:0] dn;
      logic [4:0]  inv; logic wp; logic [3:0] wn; logic [2:0] meta; logic rw; logic [2:0] sh;
   } vec_t;

   function automatic vec_t mk(int rq, int rv, int wr, int node, int ack, int vv, int vec, int done,
                               int rd, int nak, int trap, int tw, int tn, int dr, int dn,
                               int inv, int wp, int wn, int meta, int rw, int sh);
      vec_t v;
      v.rq = 4'(rq); v.rv = 1'(rv); v.wr = 1'(wr); v.node = 4'(node); v.ack = 1'(ack);
      v.vv = 1'(vv); v.vec = 16'(vec); v.done = 1'(done);
      v.rd = 1'(rd); v.nak = 1'(nak); v.trap = 1'(trap); v.tw = 1'(tw); v.tn = 4'(tn);
      v.dr = 1'(dr); v.dn = 4'(dn); v.inv = 5'(inv); v.wp = 1'(wp); v.wn = 4'(wn);
      v.meta = 3'(meta); v.rw = 1'(rw); v.sh = 3'(sh);
      return v;
   endfunction

   localparam int NT = 28;
   //                 rq rv wr nd ak vv vec     dn | rd nk tp tw tn dr dn inv wp wn mt rw sh
   localparam vec_t TBL [NT] = '{
      mk( 2, 1, 0, 3, 0, 0, 0,      0,   1, 0, 0, 0, 0, 0, 0,  0, 0, 0, 0, 0, 1), // R2
      mk( 3, 1, 0, 3, 0, 0, 0,      0,   1, 0, 0, 0, 0, 0, 0,  0, 0, 0, 0, 0, 1), // R3
      mk( 2, 1, 0, 7, 0, 0, 0,      0,   1, 0, 0, 0, 0, 0, 0,  0, 0, 0, 0, 0, 2),
      mk( 2, 1, 0, 9, 0, 0, 0,      0,   1, 0, 0, 0, 0, 0, 0,  0, 0, 0, 0, 0, 3),
      mk( 2, 1, 0, 1, 0, 0, 0,      0,   1, 0, 0, 0, 0, 0, 0,  0, 0, 0, 0, 0, 4),
      mk( 2, 1, 0,12, 0, 0, 0,      0,   1, 0, 0, 0, 0, 0, 0,  0, 0, 0, 0, 0, 5),
      mk( 4, 1, 0, 4, 0, 0, 0,      0,   0, 0, 1, 0, 4, 0, 0,  0, 0, 0, 1, 0, 5), // R4
      mk( 5, 0, 0, 0, 0, 0, 0,      0,   0, 0, 0, 0, 0, 1, 3,  0, 0, 0, 1, 0, 5), // R5
      mk( 6, 1, 0, 2, 0, 0, 0,      0,   0, 1, 0, 0, 0, 1, 7,  0, 0, 0, 1, 0, 5), // R6
      mk( 5, 0, 0, 0, 0, 0, 0,      0,   0, 0, 0, 0, 0, 1, 9,  0, 0, 0, 1, 0, 5),
      mk( 5, 0, 0, 0, 0, 0, 0,      0,   0, 0, 0, 0, 0, 1, 1,  0, 0, 0, 1, 0, 5),
      mk( 5, 0, 0, 0, 0, 0, 0,      0,   0, 0, 0, 0, 0, 1,12,  0, 0, 0, 2, 0, 0),
      mk( 7, 1, 0, 5, 0, 0, 0,      0,   0, 0, 1, 0, 5, 0, 0,  0, 0, 0, 2, 0, 0), // R7
      mk( 7, 1, 1, 6, 0, 0, 0,      0,   0, 0, 1, 1, 6, 0, 0,  0, 0, 0, 3, 0, 0),
      mk( 6, 1, 0, 8, 0, 0, 0,      0,   0, 1, 0, 0, 0, 0, 0,  0, 0, 0, 3, 0, 0),
      mk( 8, 0, 0, 0, 0, 1, 'h04C8, 0,   0, 0, 0, 0, 0, 0, 0,  0, 0, 0, 4, 0, 0), // R8
      mk( 9, 0, 0, 0, 1, 0, 0,      0,   0, 0, 0, 0, 0, 0, 0,  0, 0, 0, 4, 0, 0), // R9
      mk( 9, 0, 0, 0, 1, 0, 0,      0,   0, 0, 0, 0, 0, 0, 0,  0, 0, 0, 4, 0, 0),
      mk( 9, 0, 0, 0, 1, 0, 0,      0,   0, 0, 0, 0, 0, 0, 0,  0, 1, 6, 0, 1, 1),
      mk( 3, 1, 0, 6, 0, 0, 0,      0,   1, 0, 0, 0, 0, 0, 0,  0, 0, 0, 0, 0, 1),
      mk( 2, 1, 0, 2, 0, 0, 0,      0,   1, 0, 0, 0, 0, 0, 0,  0, 0, 0, 0, 0, 2),
      mk( 2, 1, 0,11, 0, 0, 0,      0,   1, 0, 0, 0, 0, 0, 0,  0, 0, 0, 0, 0, 3),
      mk(10, 1, 1, 2, 0, 0, 0,      0,   0, 0, 0, 0, 0, 0, 0,  5, 0, 0, 4, 0, 3), // R10
      mk( 9, 0, 0, 0, 1, 0, 0,      0,   0, 0, 0, 0, 0, 0, 0,  0, 0, 0, 4, 0, 3),
      mk( 9, 0, 0, 0, 1, 0, 0,      0,   0, 0, 0, 0, 0, 0, 0,  0, 1, 2, 0, 1, 1),
      mk(10, 1, 1, 2, 0, 0, 0,      0,   0, 0, 0, 0, 0, 0, 0,  0, 1, 2, 0, 1, 1),
      mk(12, 0, 0, 0, 1, 0, 0,      0,   0, 0, 0, 0, 0, 0, 0,  0, 0, 0, 0, 1, 1), // R12
      mk(11, 0, 0, 0, 0, 0, 0,      1,   0, 0, 0, 0, 0, 0, 0,  0, 0, 0, 0, 1, 1)  // R11
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid, req_write, ack, sw_vec_valid, sw_done;
   logic [NW-1:0] req_node;
   logic [NODES-1:0] sw_vec;
   logic rd_ack, nak, trap_valid, trap_write, drain_valid, wperm_valid, rw;
   logic [NW-1:0] trap_node, drain_node, wperm_node;
   logic [NPTR-1:0] inv_valid;
   logic [NPTR*NW-1:0] inv_node;
   logic [2:0] meta, sharers;

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   ldir_entry #(.NODES(NODES), .NPTR(NPTR)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
      .req_node_i(req_node), .ack_i(ack), .sw_vec_valid_i(sw_vec_valid), .sw_vec_i(sw_vec),
      .sw_done_i(sw_done), .rd_ack_o(rd_ack), .nak_o(nak), .trap_valid_o(trap_valid),
      .trap_write_o(trap_write), .trap_node_o(trap_node), .drain_valid_o(drain_valid),
      .drain_node_o(drain_node), .inv_valid_o(inv_valid), .inv_node_o(inv_node),
      .wperm_valid_o(wperm_valid), .wperm_node_o(wperm_node), .meta_o(meta), .rw_o(rw),
      .sharers_o(sharers)
   );

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic step(input bit rv, input bit wr, input int node, input bit ak,
                       input bit vv, input int vec, input bit done);
      @(negedge clk);
      req_valid = rv; req_write = wr; req_node = NW'(node); ack = ak;
      sw_vec_valid = vv; sw_vec = NODES'(vec); sw_done = done;
      @(posedge clk);
      #1;
   endtask

   task automatic chk_state(input string tag, input int m, input int s);
      chk(meta == 3'(m), {tag, " meta"}, meta, m);
      chk(sharers == 3'(s), {tag, " sharers"}, sharers, s);
   endtask

   initial begin
      #80000;
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      req_valid = 0; req_write = 0; req_node = '0; ack = 0;
      sw_vec_valid = 0; sw_vec = '0; sw_done = 0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      // R1 reset state
      chk_state("R1", 0, 0);
      chk(rw == 0, "R1 rw", rw, 0);
      chk({rd_ack, nak, trap_valid, drain_valid, wperm_valid, inv_valid} == '0,
          "R1 pulses", 1, 0);

      for (int i = 0; i < NT; i++) begin
         vec_t t;
         string tg;
         t = TBL[i];
         tg = $sformatf("R%0d row%0d", t.rq, i);
         step(t.rv, t.wr, t.node, t.ack, t.vv, t.vec, t.done);
         chk(rd_ack == t.rd,      {tg, " rd_ack"}, rd_ack, t.rd);
         chk(nak == t.nak,        {tg, " nak"}, nak, t.nak);
         chk(trap_valid == t.trap, {tg, " trap"}, trap_valid, t.trap);
         if (t.trap) begin
            chk(trap_write == t.tw, {tg, " trap_write"}, trap_write, t.tw);
            chk(trap_node == t.tn,  {tg, " trap_node"}, trap_node, t.tn);
         end
         chk(drain_valid == t.dr, {tg, " drain"}, drain_valid, t.dr);
         if (t.dr) chk(drain_node == t.dn, {tg, " drain_node"}, drain_node, t.dn);
         chk(inv_valid == t.inv,  {tg, " inv"}, inv_valid, t.inv);
         chk(wperm_valid == t.wp, {tg, " wperm"}, wperm_valid, t.wp);
         if (t.wp) chk(wperm_node == t.wn, {tg, " wperm_node"}, wperm_node, t.wn);
         chk(meta == t.meta,      {tg, " meta"}, meta, t.meta);
         chk(rw == t.rw,          {tg, " rw"}, rw, t.rw);
         chk(sharers == t.sh,     {tg, " sharers"}, sharers, t.sh);
      end

      // R5 drain order by slot; state now: slot0 = node 2
      step(1, 0, 1, 0, 0, 0, 0);
      step(1, 0, 3, 0, 0, 0, 0);
      step(1, 0, 4, 0, 0, 0, 0);
      step(1, 0, 5, 0, 0, 0, 0);
      chk_state("R2 fill", 0, 5);
      step(1, 0, 6, 0, 0, 0, 0);
      chk(trap_valid && trap_node == 4'd6, "R4 overflow trap", trap_node, 6);
      begin
         int exp_d [5] = '{2, 1, 3, 4, 5};
         for (int k = 0; k < 5; k++) begin
            step(0, 0, 0, 0, 0, 0, 0);
            chk(drain_valid && drain_node == 4'(exp_d[k]), "R5 drain order",
                drain_node, exp_d[k]);
         end
      end
      chk_state("R5 after drain", 2, 0);
      // R11 software complete
      step(0, 0, 0, 0, 0, 0, 1);
      chk_state("R11 done", 0, 0);

      // R10 invalidation node slots
      step(1, 0, 8, 0, 0, 0, 0);
      step(1, 0, 10, 0, 0, 0, 0);
      step(1, 1, 13, 0, 0, 0, 0);
      chk(inv_valid == 5'b00011, "R10 inv mask", inv_valid, 3);
      chk(inv_node[3:0] == 4'd8 && inv_node[7:4] == 4'd10, "R10 inv nodes",
          inv_node[7:0], 'hA8);
      step(0, 0, 0, 1, 0, 0, 0);
      chk(wperm_valid == 0, "R9 early grant", wperm_valid, 0);
      step(0, 0, 0, 1, 0, 0, 0);
      chk(wperm_valid && wperm_node == 4'd13, "R9 grant", wperm_node, 13);

      // R8 zero-count vector from the trap path
      for (int n = 1; n <= 4; n++) step(1, 0, n, 0, 0, 0, 0);
      step(1, 0, 5, 0, 0, 0, 0);
      repeat (5) step(0, 0, 0, 0, 0, 0, 0);
      chk_state("R5 second drain", 2, 0);
      step(1, 1, 9, 0, 0, 0, 0);
      chk(trap_valid && trap_write, "R7 write trap", trap_write, 1);
      chk_state("R7 vec wait", 3, 0);
      step(0, 0, 0, 0, 1, 'h0200, 0);
      chk(wperm_valid && wperm_node == 4'd9, "R8 zero count grant", wperm_node, 9);
      chk_state("R8 zero count", 0, 1);
      // R11 ignored in normal mode
      step(0, 0, 0, 0, 0, 0, 1);
      chk_state("R11 ignored", 0, 1);
      chk(rw == 1, "R11 rw kept", rw, 1);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule